// File: doc/BRIEF.md
# Pipeline exception flush controller

This block steers the front of a five-stage in-order pipeline when the normal instruction flow has to be abandoned. Its main job is an arithmetic overflow raised by the execute stage. When that happens, the faulting instruction in execute and the two younger ones in decode and fetch are squashed in the same cycle. The instruction's carried PC+4 and a cause code are latched, and the next fetch is redirected to a fixed handler address. Instructions already in memory and writeback are left alone, so they retire normally.

The same controller also handles a taken branch resolved in decode. In that case only the fetch/decode register is flushed, loading a zero instruction, and fetch is redirected to the branch target at a cost of one cycle. When both events land in the same cycle, the exception wins.

The write enable of the instruction in execute passes through the block. It is forced low on overflow, so the faulting instruction never changes its destination register. Software finds the faulting instruction by subtracting 4 from the saved address.

Top module: `exc_flush_ctrl`

## Requirements
- R1: After reset the saved exception address `epc` is 0 and `cause` is 0 (no exception).
- R2: In any cycle where `ex_ovf` is high, `flush_if`, `flush_id` and `flush_ex` are all high in that same cycle.
- R3: In a cycle with `ex_ovf` high, `pc_sel` is 2 (handler) and `next_pc` equals the handler address, 0x40000040 by default.
- R4: On the clock edge that ends an overflow cycle, `epc` loads the `ex_pc_plus4` value present in that cycle.
- R5: On the clock edge that ends an overflow cycle, `cause` loads the value 12 (arithmetic overflow).
- R6: With `id_br_taken` high and `ex_ovf` low, `flush_if` is high, `flush_id` and `flush_ex` are low, `pc_sel` is 1 (branch), and `next_pc` equals `id_br_target`.
- R7: When `ex_ovf` and `id_br_taken` are high together, the exception behaviour of R2 and R3 applies and the branch target is ignored.
- R8: With both events low, all three flush strobes are low, `pc_sel` is 0 (sequential), and `next_pc` equals `if_pc_plus4`.
- R9: In cycles without overflow, including taken-branch cycles, `epc` and `cause` keep their values.
- R10: `ex_rf_we_out` equals `ex_rf_we_in` when `ex_ovf` is low, and is low whenever `ex_ovf` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_ovf | input | 1 | Overflow flag from the execute stage |
| id_br_taken | input | 1 | Branch resolved taken in decode |
| ex_pc_plus4 | input | XLEN | PC+4 carried with the execute-stage instruction |
| id_br_target | input | XLEN | Target of the decode-stage branch |
| if_pc_plus4 | input | XLEN | Sequential fetch address |
| ex_rf_we_in | input | 1 | Register write enable of the execute-stage instruction |
| flush_if | output | 1 | Turn the fetch/decode register into a bubble |
| flush_id | output | 1 | Turn the decode/execute register into a bubble |
| flush_ex | output | 1 | Turn the execute/memory register into a bubble |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 branch, 2 handler |
| next_pc | output | XLEN | Selected next fetch address |
| ex_rf_we_out | output | 1 | Write enable after overflow suppression |
| epc | output | XLEN | Saved PC+4 of the last faulting instruction |
| cause | output | CAUSE_W | Last exception cause: 0 none, 12 overflow |

## Verification
The bench looks for a wrong latch or hold of `epc` or `cause`. Such an error shows at the ports on the first sample after the clock edge that ends the overflow cycle. It also persists through every later idle or branch cycle until the next overflow, so a late or missing update stays visible. Wrong priority or a missing strobe appears in the same cycle as the triggering input, on the flush strobes, `pc_sel` and `next_pc`. For that reason each stimulus cycle is compared against an expected item taken from the scoreboard queue.

// File: rtl/exc_flush_ctrl.sv
module exc_flush_ctrl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h4000_0040,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ex_ovf,
  input  logic               id_br_taken,
  input  logic [XLEN-1:0]    ex_pc_plus4,
  input  logic [XLEN-1:0]    id_br_target,
  input  logic [XLEN-1:0]    if_pc_plus4,
  input  logic               ex_rf_we_in,
  output logic               flush_if,
  output logic               flush_id,
  output logic               flush_ex,
  output logic [1:0]         pc_sel,
  output logic [XLEN-1:0]    next_pc,
  output logic               ex_rf_we_out,
  output logic [XLEN-1:0]    epc,
  output logic [CAUSE_W-1:0] cause
);

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = '0;
  localparam logic [CAUSE_W-1:0] CAUSE_OVF  = CAUSE_W'(12);
  localparam logic [1:0] SEL_SEQ = 2'd0;
  localparam logic [1:0] SEL_BR  = 2'd1;
  localparam logic [1:0] SEL_EXC = 2'd2;

  assign flush_ex     = ex_ovf;
  assign flush_id     = ex_ovf;
  assign flush_if     = ex_ovf | id_br_taken;
  assign ex_rf_we_out = ex_rf_we_in & ~ex_ovf;
  assign pc_sel       = ex_ovf ? SEL_EXC : (id_br_taken ? SEL_BR : SEL_SEQ);

  always_comb begin
    case (pc_sel)
      SEL_EXC: next_pc = HANDLER_ADDR;
      SEL_BR:  next_pc = id_br_target;
      default: next_pc = if_pc_plus4;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= CAUSE_NONE;
    end else if (ex_ovf) begin
      epc   <= ex_pc_plus4;
      cause <= CAUSE_OVF;
    end
  end

  AST_OVF_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |-> (flush_if && flush_id && flush_ex)); // R2
  AST_OVF_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |-> (next_pc == HANDLER_ADDR)); // R3
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |=> (epc == $past(ex_pc_plus4))); // R4
  AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |=> (cause == CAUSE_OVF)); // R5
  AST_BR_IF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_ovf && id_br_taken) |-> (flush_if && !flush_id && !flush_ex && next_pc == id_br_target)); // R6
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_ovf |=> ($stable(epc) && $stable(cause))); // R9
  AST_WE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    ex_ovf |-> !ex_rf_we_out); // R10

endmodule

// File: tb/exc_flush_ctrl_tb_top.sv
module exc_flush_ctrl_tb_top;
  localparam logic [31:0] HANDLER = 32'h4000_0040;

  logic clk = 0;
  logic rst_n = 0;
  logic ex_ovf = 0, id_br_taken = 0, ex_rf_we_in = 0;
  logic [31:0] ex_pc_plus4 = 0, id_br_target = 0, if_pc_plus4 = 0;
  logic flush_if, flush_id, flush_ex, ex_rf_we_out;
  logic [1:0] pc_sel;
  logic [31:0] next_pc, epc;
  logic [3:0] cause;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    string tag;
    logic fi, fid, fex, we;
    logic [1:0] sel;
    logic [31:0] npc, epc;
    logic [3:0] cause;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_epc = 0;
  logic [3:0] m_cause = 0;

  always #10 clk = ~clk;

  exc_flush_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ex_ovf(ex_ovf), .id_br_taken(id_br_taken),
    .ex_pc_plus4(ex_pc_plus4), .id_br_target(id_br_target), .if_pc_plus4(if_pc_plus4),
    .ex_rf_we_in(ex_rf_we_in), .flush_if(flush_if), .flush_id(flush_id),
    .flush_ex(flush_ex), .pc_sel(pc_sel), .next_pc(next_pc),
    .ex_rf_we_out(ex_rf_we_out), .epc(epc), .cause(cause));

  task automatic step(input logic ovf, input logic br, input logic we,
                      input logic [31:0] pc4, input logic [31:0] tgt,
                      input logic [31:0] seq, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    ex_ovf = ovf; id_br_taken = br; ex_rf_we_in = we;
    ex_pc_plus4 = pc4; id_br_target = tgt; if_pc_plus4 = seq;
    e.tag = tag;
    e.fi  = ovf | br;
    e.fid = ovf;
    e.fex = ovf;
    e.we  = ovf ? 1'b0 : we;
    e.sel = ovf ? 2'd2 : (br ? 2'd1 : 2'd0);
    e.npc = ovf ? HANDLER : (br ? tgt : seq);
    e.epc = m_epc;
    e.cause = m_cause;
    sb.push_back(e);
    if (ovf) begin
      m_epc = pc4;
      m_cause = 4'd12;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #10;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ({flush_if, flush_id, flush_ex} !== {e.fi, e.fid, e.fex}) begin
          failures++;
          $display("FAIL %s flush got %b%b%b exp %b%b%b", e.tag, flush_if, flush_id, flush_ex, e.fi, e.fid, e.fex);
        end
        if (pc_sel !== e.sel || next_pc !== e.npc) begin
          failures++;
          $display("FAIL %s pc_sel/next_pc got %0d/%h exp %0d/%h", e.tag, pc_sel, next_pc, e.sel, e.npc);
        end
        if (ex_rf_we_out !== e.we) begin
          failures++;
          $display("FAIL %s we got %b exp %b", e.tag, ex_rf_we_out, e.we);
        end
        if (epc !== e.epc || cause !== e.cause) begin
          failures++;
          $display("FAIL %s (R4/R5/R9) epc/cause got %h/%0d exp %h/%0d", e.tag, epc, cause, e.epc, e.cause);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (epc !== 32'h0 || cause !== 4'd0) begin
      failures++;
      $display("FAIL R1 reset epc/cause got %h/%0d exp 0/0", epc, cause);
    end
    rst_n = 1;
    step(0, 0, 1, 32'h10, 32'h99, 32'h1004, "R8 idle");
    step(0, 1, 1, 32'h14, 32'h2000, 32'h1008, "R6 branch");
    step(0, 0, 0, 32'h18, 32'h2000, 32'h2004, "R10 we passthrough low");
    step(1, 0, 1, 32'h100, 32'h0, 32'h3000, "R2 R3 R10 overflow");
    step(0, 0, 1, 32'h104, 32'h0, 32'h4000_0044, "R4 R5 capture");
    step(0, 1, 1, 32'h108, 32'h5000, 32'h4000_0048, "R9 hold on branch");
    step(1, 1, 1, 32'h200, 32'h300, 32'h5004, "R7 both events");
    step(0, 0, 1, 32'h204, 32'h0, 32'h4000_0044, "R4 second capture");
    step(1, 0, 0, 32'h444, 32'h0, 32'h6000, "R2 overflow no write");
    step(1, 0, 1, 32'h888, 32'h0, 32'h6004, "R4 back-to-back overflow");
    for (int i = 0; i < 6; i++)
      step(0, i[0], i[1], 32'h1000 + 32'(i), 32'h7000 + 32'(i), 32'h8000 + 32'(i), "R9 R8 R6 mixed");
    @(posedge clk);
    @(posedge clk);
    #15;
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule